// File: doc/BRIEF.md
# Two-Stage SCL Clock Divider

This block produces the serial-clock timing base for an I2C bus master. It runs from a fast system clock and divides it by three cascaded stages: a small prescaler A (divide by A+1), a wider prescaler B (divide by B+1), and a fixed 22-step sequencer that forms one SCL period. The result is an SCL level, high for the first 11 sequencer steps and low for the last 11, plus a one-cycle tick with a 2-bit phase code at each SCL edge and at the middle of each half. A bit-level engine can use the edge ticks to drive the line and the mid-half ticks to place its sampling and data-change points.

The control FSM has four states. IDLE keeps SCL released (high), keeps all counters clear, and copies the divisor inputs into internal holding registers every cycle. When run is seen high, IDLE goes to ARM (transition START), which freezes the divisors and issues the first rising-edge tick. ARM always goes to RUN (transition GO), where the three stages count. When run drops, RUN goes to DRAIN (transition STOP), where counting continues until the current SCL period ends. At the last step of that period, DRAIN goes back to IDLE (transition DONE) and SCL is left high.

Top module: `scl_timebase`

## Requirements
- R1: After reset, and while run stays low, scl_o is 1 and tick_o is 0.
- R2: Let N = (A+1)*(B+1), where A is div_a_i (2 bits, 0 to 3) and B is div_b_i (6 bits, 0 to 63). While running, successive falling edges of scl_o are exactly 22*N clock cycles apart. This holds at both extremes: A=0, B=0 gives a period of 22 cycles, and A=3, B=63 gives a period of 5632 cycles.
- R3: While running, each low phase of scl_o lasts 11*N cycles and each high phase lasts 11*N cycles.
- R4: If run is first sampled high at clock edge E, tick_o is 1 with phase_o = 0 during the cycle after edge E+1. scl_o first falls at edge E+1+11*N.
- R5: tick_o is always a single-cycle pulse, and exactly four ticks fall in each period. phase_o gives the point in the period: 0 is the rising edge of scl_o, 1 is the high-phase midpoint (5*N cycles after the rise), 2 is the falling edge of scl_o, and 3 is the low-phase midpoint (5*N cycles after the fall). Ticks with phase 2 and phase 0 occur in the same cycle that scl_o falls or rises.
- R6: div_a_i and div_b_i are sampled only in IDLE. A change made while running does not alter the waveform. The values present when run is next sampled high set the next run.
- R7: When run drops, the current period runs to completion. scl_o rises at the period's last step, together with a phase-0 tick, and then stays high with no further ticks. A pulse on run during DRAIN has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | 1 requests SCL generation; 0 asks the block to stop at the end of the current period |
| div_a_i | input | 2 | Prescaler A setting; divides by value+1 |
| div_b_i | input | 6 | Prescaler B setting; divides by value+1 |
| scl_o | output | 1 | SCL level: 1 means released high, 0 means driven low |
| tick_o | output | 1 | One-cycle timing tick |
| phase_o | output | 2 | Point in the period marked by the tick: 0 rise, 1 high mid, 2 fall, 3 low mid |

## Verification
Every result is timed from the edge at which run is first sampled high, counted as edge 1. The start tick is due after edge 2. The first fall is due at edge 2+11N, the first rise at 2+22N, the second fall at 2+33N, and the drain-ending rise at 2+44N. Mid-half ticks come 5N edges after each SCL edge. The bench counts edges from that starting point, samples every output on the falling clock edge, and compares the observed edge indices of each transition and each tick against these values. It drops run right after the second fall and pulses it during DRAIN, so the drain timing in R7 is checked against the same count.

// File: rtl/scl_timebase_pkg.sv
package scl_timebase_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } div_state_e;

    typedef enum logic [1:0] {
        PH_RISE    = 2'd0,
        PH_HIGHMID = 2'd1,
        PH_FALL    = 2'd2,
        PH_LOWMID  = 2'd3
    } qphase_e;

endpackage

// File: rtl/scl_prescale.sv
module scl_prescale #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         step_i,
    input  logic [W-1:0] limit_i,
    output logic         wrap_o
);

    logic [W-1:0] cnt_q;

    // a wrap consumes the step that reaches the limit
    assign wrap_o = step_i && (cnt_q == limit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || wrap_o) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_timebase_pkg::*;
#(
    parameter int HALF = 11,
    parameter int MID  = 5,
    localparam int FULL = 2 * HALF,
    localparam int CW   = $clog2(FULL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          start_i,
    input  logic          step_i,
    output logic          level_o,
    output logic          last_o,
    output logic          tick_o,
    output logic [1:0]    phase_o,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] LAST_C   = CW'(FULL - 1);
    localparam logic [CW-1:0] HALF_C   = CW'(HALF);
    localparam logic [CW-1:0] MIDH_C   = CW'(MID);
    localparam logic [CW-1:0] MIDL_C   = CW'(HALF + MID);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;
    logic          tick_q;
    qphase_e       phase_q;

    assign last_o  = (cnt_q == LAST_C);
    assign cnt_nx  = last_o ? '0 : cnt_q + CW'(1);
    assign level_o = (cnt_q < HALF_C);
    assign tick_o  = tick_q;
    assign phase_o = phase_q;
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            tick_q  <= 1'b0;
            phase_q <= PH_RISE;
        end else if (clr_i) begin
            cnt_q   <= '0;
            tick_q  <= start_i;
            phase_q <= PH_RISE;
        end else begin
            tick_q <= 1'b0;
            if (step_i) begin
                cnt_q <= cnt_nx;
                if (cnt_nx == '0) begin
                    tick_q  <= 1'b1;
                    phase_q <= PH_RISE;
                end else if (cnt_nx == MIDH_C) begin
                    tick_q  <= 1'b1;
                    phase_q <= PH_HIGHMID;
                end else if (cnt_nx == HALF_C) begin
                    tick_q  <= 1'b1;
                    phase_q <= PH_FALL;
                end else if (cnt_nx == MIDL_C) begin
                    tick_q  <= 1'b1;
                    phase_q <= PH_LOWMID;
                end
            end
        end
    end

endmodule

// File: rtl/scl_timebase.sv
module scl_timebase
    import scl_timebase_pkg::*;
#(
    parameter int A_W  = 2,
    parameter int B_W  = 6,
    parameter int HALF = 11,
    parameter int MID  = 5,
    localparam int CW  = $clog2(2 * HALF)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_i,
    input  logic [A_W-1:0] div_a_i,
    input  logic [B_W-1:0] div_b_i,
    output logic           scl_o,
    output logic           tick_o,
    output logic [1:0]     phase_o
);

    div_state_e     state_q;
    div_state_e     state_nx;
    logic [A_W-1:0] a_lat;
    logic [B_W-1:0] b_lat;
    logic           running;
    logic           clr;
    logic           start;
    logic           wrap_a;
    logic           wrap_b;
    logic           level;
    logic           last;
    logic [CW-1:0]  fcnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions: START, GO, STOP, DONE
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_i) state_nx = ST_ARM;
            ST_ARM:   state_nx = ST_RUN;
            ST_RUN:   if (!run_i) state_nx = ST_DRAIN;
            ST_DRAIN: if (wrap_b && last) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs and stage controls
    always_comb begin
        running = 1'b0;
        start   = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin running = 1'b0; start = 1'b0; end
            ST_ARM:   begin running = 1'b0; start = 1'b1; end
            ST_RUN:   begin running = 1'b1; start = 1'b0; end
            ST_DRAIN: begin running = 1'b1; start = 1'b0; end
            default:  begin running = 1'b0; start = 1'b0; end
        endcase
        clr   = !running;
        scl_o = running ? level : 1'b1;
    end

    // divisor holding registers follow the inputs only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_lat <= '0;
            b_lat <= '0;
        end else if (state_q == ST_IDLE) begin
            a_lat <= div_a_i;
            b_lat <= div_b_i;
        end
    end

    scl_prescale #(.W(A_W)) u_stage_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .step_i  (running),
        .limit_i (a_lat),
        .wrap_o  (wrap_a)
    );

    scl_prescale #(.W(B_W)) u_stage_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .step_i  (wrap_a),
        .limit_i (b_lat),
        .wrap_o  (wrap_b)
    );

    scl_phase_seq #(.HALF(HALF), .MID(MID)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .start_i (start),
        .step_i  (wrap_b),
        .level_o (level),
        .last_o  (last),
        .tick_o  (tick_o),
        .phase_o (phase_o),
        .cnt_o   (fcnt)
    );

endmodule

// File: rtl/scl_timebase_chk.sv
module scl_timebase_chk
    import scl_timebase_pkg::*;
#(
    parameter int A_W  = 2,
    parameter int B_W  = 6,
    parameter int HALF = 11,
    localparam int CW  = $clog2(2 * HALF)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           scl_o,
    input logic           tick_o,
    input logic [1:0]     phase_o,
    input div_state_e     state_q,
    input logic [A_W-1:0] a_lat,
    input logic [B_W-1:0] b_lat,
    input logic [CW-1:0]  fcnt
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> (!tick_o && scl_o));

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fcnt < CW'(2 * HALF));

    // R5
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R5
    fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_o) |-> (tick_o && phase_o == 2'd2));

    // R5
    rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_o) |-> (tick_o && phase_o == 2'd0));

    // R6
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(a_lat) && $stable(b_lat)));

endmodule

bind scl_timebase scl_timebase_chk #(
    .A_W  (A_W),
    .B_W  (B_W),
    .HALF (HALF)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_o   (scl_o),
    .tick_o  (tick_o),
    .phase_o (phase_o),
    .state_q (state_q),
    .a_lat   (a_lat),
    .b_lat   (b_lat),
    .fcnt    (fcnt)
);

// File: tb/sim_scl_timebase.sv
module sim_scl_timebase;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [1:0] div_a = '0;
    logic [5:0] div_b = '0;
    logic       scl;
    logic       tick;
    logic [1:0] phase;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    scl_timebase u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .div_a_i (div_a),
        .div_b_i (div_b),
        .scl_o   (scl),
        .tick_o  (tick),
        .phase_o (phase)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    // R1: reset and idle state
    task automatic t_reset();
        int bad = 0;
        rst_n = 1'b0;
        run   = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!scl || tick) bad++;
        end
        check(bad == 0, "R1 idle outputs after reset", bad, 0);
    endtask

    // One start/run/drain scenario; a, b set before start; ja, jb written mid-run when junk
    task automatic t_run(input int a, input int b, input bit junk, input int ja, input int jb,
                         input bit next_start);
        int n    = (a + 1) * (b + 1);
        int f1   = 2 + 11 * n;
        int r1   = 2 + 22 * n;
        int f2   = 2 + 33 * n;
        int r2   = 2 + 44 * n;
        int tf1  = -1;
        int tf2  = -1;
        int tr1  = -1;
        int tr2  = -1;
        int extra = 0;
        int tick_bad = 0;
        int first_bad = 0;
        bit prev = 1'b1;
        @(negedge clk);
        div_a = 2'(a);
        div_b = 6'(b);
        run   = 1'b1;
        for (int k = 1; k <= r2 + 30; k++) begin
            bit exp_tick;
            int exp_ph;
            int off;
            @(negedge clk);
            if (prev && !scl) begin
                if (tf1 < 0) tf1 = k; else if (tf2 < 0) tf2 = k; else extra++;
            end
            if (!prev && scl) begin
                if (tr1 < 0) tr1 = k; else if (tr2 < 0) tr2 = k; else extra++;
            end
            prev = scl;
            exp_tick = 1'b0;
            exp_ph   = 0;
            if (k >= 2 && k <= r2) begin
                off = (k - 2) % (22 * n);
                if (off == 0)           begin exp_tick = 1'b1; exp_ph = 0; end
                else if (off == 5 * n)  begin exp_tick = 1'b1; exp_ph = 1; end
                else if (off == 11 * n) begin exp_tick = 1'b1; exp_ph = 2; end
                else if (off == 16 * n) begin exp_tick = 1'b1; exp_ph = 3; end
            end
            if (tick != exp_tick || (exp_tick && int'(phase) != exp_ph)) begin
                if (tick_bad == 0) first_bad = k;
                tick_bad++;
            end
            if (junk && k == f1) begin
                div_a = 2'(ja);
                div_b = 6'(jb);
            end
            if (k == f2)     run = 1'b0;
            if (k == f2 + 8) run = 1'b1;
            if (k == f2 + 9) run = 1'b0;
        end
        check(tf1 == f1, $sformatf("R4 first fall a=%0d b=%0d", a, b), tf1, f1);
        check(tf2 - tf1 == 22 * n, $sformatf("R2 period a=%0d b=%0d", a, b), tf2 - tf1, 22 * n);
        check(tr1 - tf1 == 11 * n, $sformatf("R3 low time a=%0d b=%0d", a, b), tr1 - tf1, 11 * n);
        check(tf2 - tr1 == 11 * n, $sformatf("R3 high time a=%0d b=%0d", a, b), tf2 - tr1, 11 * n);
        check(tick_bad == 0, $sformatf("R5 tick pattern a=%0d b=%0d (first bad edge)", a, b),
              first_bad, 0);
        check(tr2 == r2 && extra == 0, $sformatf("R7 drain end a=%0d b=%0d", a, b), tr2, r2);
        if (junk)
            check(tf2 == f2, "R6 mid-run divisor change ignored", tf2, f2);
        if (next_start)
            check(tf2 - tf1 == 22 * n, "R6 new divisors used at next start", tf2 - tf1, 22 * n);
    endtask

    initial begin
        t_reset();
        t_run(0, 0, 1'b0, 0, 0, 1'b0);
        t_run(1, 2, 1'b1, 3, 5, 1'b0);
        t_run(3, 5, 1'b0, 0, 0, 1'b1);
        t_run(2, 0, 1'b1, 0, 9, 1'b0);
        t_run(0, 63, 1'b0, 0, 0, 1'b0);
        t_run(3, 63, 1'b0, 0, 0, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule